// File: doc/BRIEF.md
# Strip-Mined Vector Multiply-Accumulate Engine

The engine runs the update y[i] = a*x[i] + y[i] over two arrays of 32-bit signed integers held in a word-addressed memory. Software, or a controlling block, supplies the element count, the scalar multiplier and the byte base addresses of both arrays, then pulses start. The engine works through the arrays in passes of up to `LANES` elements. Each pass first picks an active length equal to the smaller of `LANES` and the elements still outstanding. It then builds a contiguous lane-enable mask from that length, reads x and then y under the mask, forms the lane-wise products and sums, and writes y back under the mask.

The same loop serves every length, so the array tail needs no separate cleanup. The last pass simply enables fewer lanes. A count of zero enables no lane at all and finishes without touching memory. The memory port carries one address, read enable, write enable and data word per lane, and read data returns one cycle after the read enable.

Top module: `vmac_engine`

## Requirements
- R1: At the start of each pass the active length is set to min(LANES, remaining count). That number of elements is processed in the pass, so a job of n elements takes ceil(n/LANES) store cycles.
- R2: The lane-enable mask of a pass is (1 << active length) - 1. Lane k is enabled exactly when k < active length.
- R3: Each enabled lane writes the low 32 bits of a*x[k] + y[k]. The multiply and the add both wrap modulo 2^32.
- R4: After each pass both byte pointers advance by 4 times the active length, and the remaining count drops by the active length.
- R5: Passes repeat while the remaining count is nonzero, and the engine stops exactly when it reaches zero. No word past y[n-1] is written.
- R6: A start with n = 0 produces no read and no write, and still completes with a done pulse.
- R7: The scalar a is broadcast to every lane, so every active lane multiplies by the same value.
- R8: A disabled lane raises neither its read nor its write enable, and the memory word it would address keeps its contents.
- R9: done_o is high for exactly one cycle, after the last store of the job. busy_o is high from the cycle after an accepted start until done_o falls.
- R10: start_i is ignored while busy_o is high. A start pulse during a job changes neither its result nor its length.
- R11: Lane k addresses base + 4*k within a pass. Read data is taken one cycle after the read enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job when idle |
| len_i | input | 32 | Element count n |
| scal_i | input | 32 | Scalar multiplier a |
| xbase_i | input | AW | Byte base address of x |
| ybase_i | input | AW | Byte base address of y |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | LANES | Per-lane read enable |
| mem_we_o | output | LANES | Per-lane write enable |
| mem_addr_o | output | LANES*AW | Per-lane byte address, lane 0 in the low bits |
| mem_wdata_o | output | LANES*32 | Per-lane write data |
| mem_rdata_i | input | LANES*32 | Per-lane read data, one cycle after the read enable |

## Verification
The bench aims at the lengths around the lane count: 0, 1, LANES-1, LANES and LANES+1, plus a long length that is not a multiple of LANES. It also places guard words directly after each y array. An engine that built a full mask on the last pass would overwrite those guard words. One that decremented the count by bytes instead of elements would stop early and leave y elements unchanged. One that tested for zero only after a pass would touch memory on a zero-length job. Negative and large scalars expose a multiply that does not wrap. A start pulse sent in the middle of a job catches an engine that reloads its operands while busy.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SETVL = 3'd1,
    ST_LDX = 3'd2,
    ST_LDY = 3'd3,
    ST_WB = 3'd4,
    ST_DONE = 3'd5
  } vmac_state_e;
endpackage

// File: rtl/vmac_len.sv
module vmac_len #(
  parameter int unsigned LANES = 4,
  localparam int unsigned VLW = $clog2(LANES + 1)
) (
  input  logic [31:0]      rem_i,
  output logic [VLW-1:0]   vl_o,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    if (rem_i < 32'(LANES)) vl_o = rem_i[VLW-1:0];
    else vl_o = VLW'(LANES);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign mask_o[k] = (VLW'(k) < vl_o);
  end
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane #(
  parameter int unsigned AW = 16,
  parameter int unsigned LANE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_x_i,
  input  logic          sel_y_i,
  input  logic [AW-1:0] xptr_i,
  input  logic [AW-1:0] yptr_i,
  input  logic [31:0]   scal_i,
  input  logic [31:0]   rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   res_o
);
  logic [31:0] x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_q <= '0;
    else if (cap_x_i) x_q <= rdata_i;
  end

  assign addr_o = (sel_y_i ? yptr_i : xptr_i) + AW'(4 * LANE);
  // low 32 bits of product equal for signed and unsigned
  assign res_o = scal_i * x_q + rdata_i;
endmodule

// File: rtl/vmac_engine.sv
module vmac_engine
  import vmac_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned AW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [31:0]         len_i,
  input  logic [31:0]         scal_i,
  input  logic [AW-1:0]       xbase_i,
  input  logic [AW-1:0]       ybase_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [LANES-1:0]    mem_re_o,
  output logic [LANES-1:0]    mem_we_o,
  output logic [LANES*AW-1:0] mem_addr_o,
  output logic [LANES*DW-1:0] mem_wdata_o,
  input  logic [LANES*DW-1:0] mem_rdata_i
);
  localparam int unsigned VLW = $clog2(LANES + 1);

  vmac_state_e     state_q;
  logic [31:0]     rem_q, scal_q;
  logic [AW-1:0]   px_q, py_q;
  logic [VLW-1:0]  vl_q, vl_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic            sel_y, cap_x;

  vmac_len #(.LANES(LANES)) u_len (
    .rem_i (rem_q),
    .vl_o  (vl_d),
    .mask_o(mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      scal_q  <= '0;
      px_q    <= '0;
      py_q    <= '0;
      vl_q    <= '0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q   <= len_i;
          scal_q  <= scal_i;
          px_q    <= xbase_i;
          py_q    <= ybase_i;
          state_q <= ST_SETVL;
        end
        ST_SETVL: begin
          vl_q    <= vl_d;
          mask_q  <= mask_d;
          state_q <= (rem_q == '0) ? ST_DONE : ST_LDX;
        end
        ST_LDX: state_q <= ST_LDY;
        ST_LDY: state_q <= ST_WB;
        ST_WB: begin
          px_q    <= px_q + (AW'(vl_q) << 2);
          py_q    <= py_q + (AW'(vl_q) << 2);
          rem_q   <= rem_q - 32'(vl_q);
          state_q <= ST_SETVL;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_y    = (state_q == ST_LDY) || (state_q == ST_WB);
  assign cap_x    = (state_q == ST_LDY);
  assign mem_re_o = (state_q == ST_LDX || state_q == ST_LDY) ? mask_q : '0;
  assign mem_we_o = (state_q == ST_WB) ? mask_q : '0;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vmac_lane #(.AW(AW), .LANE(k)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_x_i(cap_x),
      .sel_y_i(sel_y),
      .xptr_i (px_q),
      .yptr_i (py_q),
      .scal_i (scal_q),
      .rdata_i(mem_rdata_i[k*DW +: DW]),
      .addr_o (mem_addr_o[k*AW +: AW]),
      .res_o  (mem_wdata_o[k*DW +: DW])
    );
  end

  // mask is always contiguous from lane 0
  assert_mask_contig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({1'b0, mask_q} + {{LANES{1'b0}}, 1'b1}) || (&mask_q));

  assert_vl_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LDX) |-> (vl_q != '0 && 32'(vl_q) <= rem_q && vl_q <= VLW'(LANES)));

  assert_rem_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |=> (rem_q == $past(rem_q) - 32'($past(vl_q))));

  assert_write_after_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_we_o) |-> ($past(mem_re_o) == mem_we_o));

  assert_zero_noacc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_we_o == '0 && mem_re_o == '0));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_stop_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (rem_q == '0));

  assert_ignore_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_WB) |=> $stable(rem_q) && $stable(scal_q));
endmodule

// File: tb/tb_vmac_engine.sv
module tb_vmac_engine;
  localparam int unsigned LANES = 4;
  localparam int unsigned AW = 16;
  localparam int unsigned MW = 256;

  typedef struct packed {
    logic [31:0] n;
    logic [31:0] a;
    logic [15:0] xw;
    logic [15:0] yw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{n: 32'd0,  a: 32'd7,          xw: 16'd8,  yw: 16'd128},
    '{n: 32'd1,  a: 32'hFFFF_FFFD,  xw: 16'd9,  yw: 16'd130},
    '{n: 32'd3,  a: 32'd12345,      xw: 16'd10, yw: 16'd133},
    '{n: 32'd4,  a: 32'h8000_0001,  xw: 16'd12, yw: 16'd136},
    '{n: 32'd5,  a: 32'h7FFF_FFFF,  xw: 16'd20, yw: 16'd141},
    '{n: 32'd23, a: 32'hDEAD_BEEF,  xw: 16'd40, yw: 16'd150}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] len = '0, scal = '0;
  logic [AW-1:0] xbase = '0, ybase = '0;
  logic busy, done;
  logic [LANES-1:0] re, we;
  logic [LANES*AW-1:0] addr;
  logic [LANES*32-1:0] wdata;
  logic [LANES*32-1:0] rdata = '0;

  logic [31:0] mem [MW];
  logic [31:0] snap [MW];
  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vmac_engine #(.LANES(LANES), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .scal_i(scal),
    .xbase_i(xbase), .ybase_i(ybase), .busy_o(busy), .done_o(done),
    .mem_re_o(re), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (|re) rd_cnt <= rd_cnt + 1;
    if (|we) wr_cnt <= wr_cnt + 1;
    for (int k = 0; k < LANES; k++) begin
      if (re[k]) rdata[k*32 +: 32] <= mem[addr[k*AW+2 +: 8]];
      if (we[k]) mem[addr[k*AW+2 +: 8]] <= wdata[k*32 +: 32];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int w = 0; w < MW; w++) begin
      mem[w] = (32'(w) * 32'h9E37_79B1) ^ 32'(seed * 32'h0101_0107);
      snap[w] = mem[w];
    end
  endtask

  // drive a job and wait; optional stray start mid-job
  task automatic run(input vec_t v, input bit stray, output int dwidth);
    int t;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    len = v.n; scal = v.a; xbase = AW'(v.xw) << 2; ybase = AW'(v.yw) << 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 1000) begin
      if (stray && t == 5) begin
        len = 32'd0; scal = 32'd1; xbase = 16'h0; ybase = 16'h0; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    dwidth = 0;
    while (done && dwidth < 5) begin
      dwidth++;
      @(negedge clk);
    end
  endtask

  task automatic verify(input vec_t v, input int dw, input string tag);
    int bad = 0;
    int passes = (int'(v.n) + LANES - 1) / LANES;
    for (int i = 0; i < int'(v.n); i++) begin
      logic [31:0] e;
      e = v.a * snap[v.xw + i] + snap[v.yw + i];
      if (mem[v.yw + i] !== e) begin
        bad++;
        if (bad == 1) check({tag, " R3 R4 R7 element"}, mem[v.yw + i], e);
      end
    end
    if (bad == 0) check({tag, " R3 R4 R7 element"}, 0, 0);
    // guard words after the array and before it
    check({tag, " R5 R8 guard after"}, mem[v.yw + v.n], snap[v.yw + v.n]);
    check({tag, " R8 guard before"}, mem[v.yw - 1], snap[v.yw - 1]);
    check({tag, " R1 R5 store cycles"}, wr_cnt, passes);
    check({tag, " R11 read cycles"}, rd_cnt, 2 * passes);
    check({tag, " R9 done width"}, dw, 1);
    check({tag, " R9 busy low after"}, busy, 0);
  endtask

  initial begin
    int dw;
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int dw;
    fill(1);
    repeat (3) @(negedge clk);
    check("R9 reset busy", busy, 0);
    check("R9 reset done", done, 0);
    check("R8 reset re/we", {re, we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      fill(i + 2);
      run(VECS[i], 1'b0, dw);
      verify(VECS[i], dw, $sformatf("vec%0d n=%0d", i, VECS[i].n));
    end

    // R6: zero length, nothing touched anywhere
    fill(9);
    run(VECS[0], 1'b0, dw);
    begin
      int diff = 0;
      for (int w = 0; w < MW; w++) if (mem[w] !== snap[w]) diff++;
      check("R6 zero-length memory untouched", diff, 0);
      check("R6 zero-length reads", rd_cnt, 0);
      check("R6 zero-length writes", wr_cnt, 0);
    end

    // R10: stray start while busy
    begin
      vec_t v;
      v = '{n: 32'd11, a: 32'd3, xw: 16'd60, yw: 16'd200};
      fill(11);
      run(v, 1'b1, dw);
      verify(v, dw, "R10 stray start");
      check("R10 word 0 untouched", mem[0], snap[0]);
    end

    // R7: broadcast with a=1 gives x+y in every lane
    begin
      vec_t v;
      v = '{n: 32'd8, a: 32'd1, xw: 16'd70, yw: 16'd220};
      fill(13);
      run(v, 1'b0, dw);
      for (int i = 0; i < 8; i++)
        check("R7 R2 lane sum", mem[220 + i], snap[70 + i] + snap[220 + i]);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule